// File: doc/BRIEF.md
# Outer-Bank PRG/CHR Address Extender

This block sits beside a scanline-counting bank-switching core on a CPU bus. The core yields a raw 8 KB program page and a raw 1 KB pattern bank. This block widens both into the final bank numbers that address the program ROM and the pattern ROM. Two configuration bytes control the widening. They are written through the CPU bus at fixed addresses: an outer-bank byte at $5001 and an override byte at $5000.

The outer byte supplies the high bank bits. Its bit 3 chooses how many raw bits stay under the core's control. When bit 7 of the override byte is set, the whole $8000-$FFFF window shows one fixed 32 KB block, and the core's program registers have no effect there. The $6000-$7FFF work-RAM window is not touched by any of this. The final numbers are cut to the physical address widths, and that cut is what wraps a bank number onto a smaller ROM.

Top module: `obx_bank_extender`

## Requirements
- R1: After a synchronous reset the override byte is 0x00 and the outer byte is 0xFF. With raw page 0x1F at $E000 the program bank is 0x7F, and with raw pattern bank 0x00 the pattern bank is 0x300.
- R2: Only a write strobe with address exactly $5000 (override byte) or exactly $5001 (outer byte) changes a configuration byte, and the new value takes effect after that clock edge. Other addresses such as $5002, $4FFF or $D001 leave the outputs unchanged, and so does $5001 with the strobe low.
- R3: In $8000-$FFFF with no override and outer bit 3 set, program bank bits 4:0 equal raw page bits 4:0.
- R4: In $8000-$FFFF with no override and outer bit 3 clear, program bank bits 3:0 equal raw page bits 3:0, and program bank bit 4 equals outer bit 4.
- R5: In $8000-$FFFF, program bank bits 6:5 equal outer bits 1:0, and program bank bit 7 is 0.
- R6: With outer bit 3 clear, pattern bank bit 7 equals outer bit 4, and pattern bank bits 6:0 equal raw bits 6:0.
- R7: With outer bit 3 set, pattern bank bits 7:0 equal the raw bank, and in every case pattern bank bits 9:8 equal outer bits 1:0.
- R8: When override bit 7 is set, a page is built for an access in $8000-$FFFF. Its bits 1:0 are address bits 14:13, its bits 5:2 are override bits 3:0, and its bits 7:6 are outer bits 1:0. That page goes through the R3/R4/R5 adjustment in place of the raw page, so the raw page has no effect.
- R9: In $6000-$7FFF the program bank equals the raw page unchanged, whether or not override mode is on.
- R10: The program and pattern bank outputs are the low PRG_W and CHR_W bits of the full 8-bit and 10-bit results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| raw_prg_page | input | 8 | Raw 8 KB page from the banking core |
| raw_chr_bank | input | 8 | Raw 1 KB pattern bank from the banking core |
| prg_bank | output | PRG_W | Final program bank |
| chr_bank | output | CHR_W | Final pattern bank |

## Verification
The bench builds two instances that share every input. The first uses full widths (PRG_W=8, CHR_W=10), so every outer, override and pass-through bit of the result can be seen at the ports. The second uses narrow widths (PRG_W=5, CHR_W=8) and shows the truncation that wraps onto smaller ROMs. Each of its results must equal the full result masked to the low bits. With the full width, the top bit shows both the raw pass-through in the work-RAM window and the forced zero in the ROM window.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int PRG_FULL_W = 8;
  localparam int CHR_FULL_W = 10;

  typedef struct packed {
    logic [7:0] ovr;    // bit 7 enables fixed 32 KB block, bits 3:0 pick it
    logic [7:0] outer;  // bits 1:0 high bank bits, bit 3 split, bit 4 extra
  } cfg_t;

  localparam logic [7:0] OVR_RST   = 8'h00;
  localparam logic [7:0] OUTER_RST = 8'hFF;

  // inner/outer split applied to an 8-bit page number
  function automatic logic [PRG_FULL_W-1:0] prg_adjust(input logic [7:0] page,
                                                       input logic [7:0] outer);
    logic [4:0] inner;
    inner = outer[3] ? page[4:0] : {outer[4], page[3:0]};
    return {1'b0, outer[1:0], inner};
  endfunction

  // page selected inside the fixed 32 KB block
  function automatic logic [7:0] ovr_page(input logic [7:0] ovr,
                                          input logic [7:0] outer,
                                          input logic [1:0] slot);
    return {outer[1:0], ovr[3:0], slot};
  endfunction

  function automatic logic [CHR_FULL_W-1:0] chr_adjust(input logic [7:0] raw,
                                                       input logic [7:0] outer);
    logic b7;
    b7 = outer[3] ? raw[7] : outer[4];
    return {outer[1:0], b7, raw[6:0]};
  endfunction
endpackage

// File: rtl/obx_cfg_regs.sv
module obx_cfg_regs
  import obx_pkg::*;
#(
  parameter logic [15:0] OVR_ADDR   = 16'h5000,
  parameter logic [15:0] OUTER_ADDR = 16'h5001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_we,
  output cfg_t        cfg
);
  logic wr_ovr, wr_outer;
  assign wr_ovr   = cpu_we && (cpu_addr == OVR_ADDR);
  assign wr_outer = cpu_we && (cpu_addr == OUTER_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.ovr   <= OVR_RST;
      cfg.outer <= OUTER_RST;
    end else begin
      if (wr_ovr)   cfg.ovr   <= cpu_wdata;
      if (wr_outer) cfg.outer <= cpu_wdata;
    end
  end

  p_rst_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg.ovr == OVR_RST && cfg.outer == OUTER_RST));
  p_wr_ovr_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ovr |=> cfg.ovr == $past(cpu_wdata));
  p_wr_outer_r2: assert property (@(posedge clk) disable iff (rst)
    wr_outer |=> cfg.outer == $past(cpu_wdata));
  p_hold_ovr_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_ovr |=> $stable(cfg.ovr));
  p_hold_outer_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_outer |=> $stable(cfg.outer));
endmodule

// File: rtl/obx_prg_map.sv
module obx_prg_map
  import obx_pkg::*;
#(
  parameter int PRG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       raw_prg_page,
  input  cfg_t             cfg,
  output logic [PRG_W-1:0] prg_bank
);
  logic                  rom_win, ram_win, ovr_active;
  logic [1:0]            slot;
  logic [7:0]            page_sel;
  logic [PRG_FULL_W-1:0] rom_full, full;

  assign rom_win    = cpu_addr[15];
  assign ram_win    = (cpu_addr[15:13] == 3'b011);
  assign slot       = cpu_addr[14:13];
  assign ovr_active = rom_win && cfg.ovr[7];

  always_comb begin
    page_sel = ovr_active ? ovr_page(cfg.ovr, cfg.outer, slot) : raw_prg_page;
    rom_full = prg_adjust(page_sel, cfg.outer);
    full     = ram_win ? raw_prg_page : rom_full;
  end

  assign prg_bank = full[PRG_W-1:0];

  initial begin
    a_width_ok: assert (PRG_W >= 1 && PRG_W <= PRG_FULL_W);
  end

  p_ovr_slot_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_active |-> full[1:0] == cpu_addr[14:13]);
  p_outer_bits_r5: assert property (@(posedge clk) disable iff (rst)
    rom_win |-> (full[6:5] == cfg.outer[1:0] && !full[7]));
  p_ram_pass_r9: assert property (@(posedge clk) disable iff (rst)
    ram_win |-> full == raw_prg_page);
  p_split_r4: assert property (@(posedge clk) disable iff (rst)
    (rom_win && !cfg.outer[3]) |-> full[4] == cfg.outer[4]);
endmodule

// File: rtl/obx_chr_map.sv
module obx_chr_map
  import obx_pkg::*;
#(
  parameter int CHR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       raw_chr_bank,
  input  cfg_t             cfg,
  output logic [CHR_W-1:0] chr_bank
);
  logic [CHR_FULL_W-1:0] full;

  always_comb full = chr_adjust(raw_chr_bank, cfg.outer);
  assign chr_bank = full[CHR_W-1:0];

  initial begin
    a_width_ok: assert (CHR_W >= 1 && CHR_W <= CHR_FULL_W);
  end

  p_low_pass_r6: assert property (@(posedge clk) disable iff (rst)
    full[6:0] == raw_chr_bank[6:0]);
  p_high_bits_r7: assert property (@(posedge clk) disable iff (rst)
    full[9:8] == cfg.outer[1:0]);
  p_bit7_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg.outer[3] |-> full[7] == cfg.outer[4]);
endmodule

// File: rtl/obx_bank_extender.sv
module obx_bank_extender
  import obx_pkg::*;
#(
  parameter int PRG_W = 8,
  parameter int CHR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_wdata,
  input  logic             cpu_we,
  input  logic [7:0]       raw_prg_page,
  input  logic [7:0]       raw_chr_bank,
  output logic [PRG_W-1:0] prg_bank,
  output logic [CHR_W-1:0] chr_bank
);
  cfg_t cfg;

  obx_cfg_regs u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cfg(cfg)
  );

  obx_prg_map #(.PRG_W(PRG_W)) u_prg (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .raw_prg_page(raw_prg_page),
    .cfg(cfg), .prg_bank(prg_bank)
  );

  obx_chr_map #(.CHR_W(CHR_W)) u_chr (
    .clk(clk), .rst(rst), .raw_chr_bank(raw_chr_bank), .cfg(cfg),
    .chr_bank(chr_bank)
  );
endmodule

// File: tb/sim_obx_bank_extender.sv
module sim_obx_bank_extender;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [7:0]  raw_prg_page = 8'h00;
  logic [7:0]  raw_chr_bank = 8'h00;
  logic [7:0]  prg_w;
  logic [9:0]  chr_w;
  logic [4:0]  prg_n;
  logic [7:0]  chr_n;

  int total = 0;
  int bad = 0;
  int sh_ovr = 0;
  int sh_outer = 255;

  always #4 clk = ~clk;

  obx_bank_extender #(.PRG_W(8), .CHR_W(10)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .raw_prg_page(raw_prg_page), .raw_chr_bank(raw_chr_bank),
    .prg_bank(prg_w), .chr_bank(chr_w)
  );

  obx_bank_extender #(.PRG_W(5), .CHR_W(8)) u1 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .raw_prg_page(raw_prg_page), .raw_chr_bank(raw_chr_bank),
    .prg_bank(prg_n), .chr_bank(chr_n)
  );

  function automatic int exp_prg(int a, int raw);
    int p, inner;
    if (a >= 'h6000 && a < 'h8000) return raw;
    p = raw;
    if (a >= 'h8000 && (sh_ovr & 'h80) != 0)
      p = (((sh_ovr & 15) + ((sh_outer << 4) & 'h30)) * 4) + ((a >> 13) & 3);
    if ((sh_outer & 8) != 0) inner = p % 32;
    else inner = (p % 16) + (sh_outer & 16);
    return ((sh_outer << 5) & 'h60) + inner;
  endfunction

  function automatic int exp_chr(int raw);
    int lo;
    if ((sh_outer & 8) != 0) lo = raw & 255;
    else lo = ((sh_outer << 3) & 'h80) + (raw & 127);
    return ((sh_outer << 8) & 'h300) + lo;
  endfunction

  task automatic chk(string req, string what, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, expv);
    end
  endtask

  task automatic probe(string req, int a, int rp, int rc);
    int ep, ec;
    @(negedge clk);
    cpu_addr = a[15:0]; raw_prg_page = rp[7:0]; raw_chr_bank = rc[7:0];
    #1;
    ep = exp_prg(a, rp);
    ec = exp_chr(rc);
    chk(req, "prg", int'(prg_w), ep);
    chk(req, "chr", int'(chr_w), ec);
    chk("R10", "narrow prg", int'(prg_n), ep % 32);
    chk("R10", "narrow chr", int'(chr_n), ec % 256);
  endtask

  task automatic bus_wr(int a, int d, bit we);
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_wdata = d[7:0]; cpu_we = we;
    @(negedge clk);
    cpu_we = 1'b0;
    if (we && a == 'h5000) sh_ovr = d;
    if (we && a == 'h5001) sh_outer = d;
  endtask

  task automatic t_reset;
    probe("R1", 'hE000, 'h1F, 'h00);
    chk("R1", "reset prg", int'(prg_w), 'h7F);
    chk("R1", "reset chr", int'(chr_w), 'h300);
  endtask

  task automatic t_decode;
    bus_wr('h5002, 'h00, 1'b1);
    bus_wr('h4FFF, 'h00, 1'b1);
    bus_wr('hD001, 'h00, 1'b1);
    bus_wr('h5001, 'h00, 1'b0);
    bus_wr('h4000, 'h80, 1'b1);
    probe("R2", 'h8000, 'h03, 'h11);
    chk("R2", "ignored writes prg", int'(prg_w), 'h63);
    bus_wr('h5001, 'h08, 1'b1);
    probe("R2", 'h8000, 'h03, 'h11);
    chk("R2", "outer write prg", int'(prg_w), 'h03);
  endtask

  task automatic t_prg_wide;
    bus_wr('h5001, 'h08, 1'b1);
    probe("R3", 'hA000, 'h1F, 0);
    probe("R3", 'hC123, 'h07, 0);
    bus_wr('h5001, 'h0B, 1'b1);
    probe("R5", 'hE000, 'h15, 0);
    chk("R5", "outer bits", int'(prg_w), 'h75);
    probe("R3", 'h9FFF, 'hFE, 0);
  endtask

  task automatic t_prg_narrow;
    bus_wr('h5001, 'h10, 1'b1);
    probe("R4", 'h8000, 'h02, 0);
    chk("R4", "bit4 from outer", int'(prg_w), 'h12);
    bus_wr('h5001, 'h00, 1'b1);
    probe("R4", 'hA000, 'h1F, 0);
    chk("R4", "bit4 cleared", int'(prg_w), 'h0F);
    bus_wr('h5001, 'h12, 1'b1);
    probe("R5", 'hC000, 'h05, 0);
    chk("R5", "outer 2", int'(prg_w), 'h55);
  endtask

  task automatic t_chr;
    bus_wr('h5001, 'h10, 1'b1);
    probe("R6", 'h8000, 0, 'h00);
    chk("R6", "bit7 from outer", int'(chr_w), 'h80);
    bus_wr('h5001, 'h00, 1'b1);
    probe("R6", 'h8000, 0, 'hFF);
    chk("R6", "bit7 cleared", int'(chr_w), 'h7F);
    bus_wr('h5001, 'h08, 1'b1);
    probe("R7", 'h8000, 0, 'hA5);
    chk("R7", "pass-through", int'(chr_w), 'hA5);
    bus_wr('h5001, 'h0B, 1'b1);
    probe("R7", 'h8000, 0, 'h81);
    chk("R7", "high bits", int'(chr_w), 'h381);
  endtask

  task automatic t_override;
    bus_wr('h5001, 'h08, 1'b1);
    bus_wr('h5000, 'h81, 1'b1);
    for (int s = 0; s < 4; s++) begin
      probe("R8", 'h8000 + s * 'h2000, 'h1F - s, 'h00);
      chk("R8", "slot page", int'(prg_w), 4 + s);
    end
    bus_wr('h5001, 'h03, 1'b1);
    bus_wr('h5000, 'h8F, 1'b1);
    probe("R8", 'hA000, 'h00, 0);
    chk("R8", "outer block", int'(prg_w), 'h6D);
    probe("R8", 'hE000, 'hFF, 0);
    bus_wr('h5000, 'h01, 1'b1);
    probe("R8", 'hA000, 'h04, 0);
    chk("R8", "override off", int'(prg_w), 'h64);
  endtask

  task automatic t_ram_window;
    bus_wr('h5000, 'h85, 1'b1);
    probe("R9", 'h6000, 'hB3, 0);
    chk("R9", "ram pass", int'(prg_w), 'hB3);
    probe("R9", 'h7FFF, 'h4E, 0);
    chk("R9", "ram pass end", int'(prg_w), 'h4E);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_prg_wide();
    t_prg_narrow();
    t_chr();
    t_override();
    t_ram_window();
    bus_wr('h5001, 'h00, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sh_ovr = 0;
    sh_outer = 255;
    probe("R1", 'hE000, 'h1F, 'h00);
    chk("R1", "re-reset prg", int'(prg_w), 'h7F);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule